// File: doc/BRIEF.md
# Parallel Port FIFO Service Interrupt Controller

This block sits behind a parallel port and holds a small byte FIFO between the host and the peripheral. It keeps track of how many bytes the FIFO holds, compares that against a programmable threshold and decides when the host should be asked for service. The host sets a mask bit, a DMA mode bit, a transfer direction, an error-interrupt enable, an acknowledge-interrupt enable and a 4-bit threshold field. The block also watches a DMA terminal-count strobe and two peripheral status lines, a fault line and an acknowledge line, both active low.

The interrupt output is built for a shared, open-drain style host interrupt line. It has two signals. `irq_oe` is the drive enable and `irq_val` is the value driven. When a service event occurs, the block drives the line low for a fixed number of clock cycles and then releases it. Other sources on the same line can then pull it. Level conditions such as "enough bytes present" raise one pulse when they become true. They do not raise a pulse on every cycle they stay true. Releasing the mask while a condition already holds raises a pulse at once.

Top module: `pp_fifo_irq`

## Requirements
- R1: The FIFO holds up to DEPTH (16) bytes and returns them in push order at `pop_data`. `fifo_count` gives the occupancy. A push while full is ignored, and so is a pop while empty.
- R2: After reset, and in any cycle in which `fifo_en` is low, the FIFO is empty (`fifo_count` = 0, `fifo_empty` = 1) and any earlier contents are discarded.
- R3: The effective threshold is `thr` + 1 (1 to 16). With `svc_mask`=0, `dma_mode`=0 and `dir_in`=1 (peripheral to host), a pulse is raised when the occupancy rises to at least the effective threshold.
- R4: With `svc_mask`=0, `dma_mode`=0 and `dir_in`=0 (host to peripheral), a pulse is raised when the free space (DEPTH minus occupancy) rises to at least the effective threshold.
- R5: A threshold condition that stays true raises exactly one pulse. Clearing `svc_mask` from 1 to 0 while the condition holds raises a pulse immediately.
- R6: While `svc_mask`=1, neither the threshold conditions nor DMA terminal count raise a pulse.
- R7: With `svc_mask`=0 and `dma_mode`=1, every cycle in which `dma_tc` is high raises a pulse. Threshold conditions raise none in DMA mode.
- R8: With `err_en_n`=0, a falling edge of `fault_n` raises a pulse. Changing `err_en_n` from 1 to 0 while `fault_n` is low also raises a pulse. A rising edge of `fault_n` raises none.
- R9: With `ack_en`=1, a rising edge of `ack_n` raises a pulse. Falling edges raise none, and nothing is raised while `ack_en`=0.
- R10: A pulse drives `irq_oe`=1 with `irq_val`=0 for exactly PULSE_W cycles, starting the cycle after the edge at which the event is sampled. A new event during a pulse restarts the count.
- R11: After reset, `irq_oe` is 0 and `irq_val` is 1 (line released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO enable; low keeps the FIFO empty |
| svc_mask | input | 1 | 1 masks threshold and DMA service interrupts |
| dma_mode | input | 1 | 1 selects DMA transfers, 0 programmed I/O |
| dir_in | input | 1 | 1 = peripheral to host, 0 = host to peripheral |
| err_en_n | input | 1 | Active-low enable of the fault interrupt |
| ack_en | input | 1 | Enable of the acknowledge interrupt |
| thr | input | TW (4) | Threshold field; effective threshold is thr+1 |
| push | input | 1 | Write one byte into the FIFO |
| push_data | input | DW (8) | Byte to write |
| pop | input | 1 | Remove the oldest byte |
| pop_data | output | DW (8) | Oldest byte in the FIFO |
| fifo_count | output | CW (5) | Occupancy |
| fifo_full | output | 1 | Occupancy equals DEPTH |
| fifo_empty | output | 1 | Occupancy is zero |
| dma_tc | input | 1 | DMA terminal-count strobe |
| fault_n | input | 1 | Peripheral fault status, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| irq_oe | output | 1 | Interrupt line drive enable |
| irq_val | output | 1 | Value driven on the interrupt line (0 while pulsing) |

## Verification
The bench builds the block with the default depth of 16 and the full 4-bit threshold, so every effective threshold from 1 to 16 is swept in both transfer directions. For each combination, the occupancy and free-space crossings are checked byte by byte against arithmetic expectations. PULSE_W is raised to 3 so that a wrong pulse length cannot match by accident. A retriggered pulse has a distinct, predictable width of PULSE_W+2.

// File: rtl/pp_fifo_irq_pkg.sv
package pp_fifo_irq_pkg;

  // One bit per source of a service event
  typedef struct packed {
    logic thr;
    logic dma;
    logic err;
    logic ack;
  } irq_src_t;

  typedef enum logic {
    DIR_TO_PERIPH   = 1'b0,
    DIR_FROM_PERIPH = 1'b1
  } xfer_dir_e;

endpackage

// File: rtl/pp_fifo_store.sv
module pp_fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = en & push & ~full;
  assign do_pop  = en & pop & ~empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (!en) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = ptr_next(wr_q);
      if (do_pop)  rd_d = ptr_next(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage array: written only under its enable, no reset needed
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  assign pop_data = mem[rd_q];
  assign count    = cnt_q;

endmodule

// File: rtl/pp_irq_detect.sv
module pp_irq_detect
  import pp_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TW    = 4,
  parameter int CW    = 5,
  localparam int KW   = ((TW + 1) > CW) ? (TW + 1) : CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          svc_mask,
  input  logic          dma_mode,
  input  logic          dir_in,
  input  logic          err_en_n,
  input  logic          ack_en,
  input  logic [TW-1:0] thr,
  input  logic [CW-1:0] count,
  input  logic          dma_tc,
  input  logic          fault_n,
  input  logic          ack_n,
  output logic          evt
);

  localparam logic [KW-1:0] DEPTH_K = KW'(DEPTH);

  logic [KW-1:0] thr_eff, level;
  logic          thr_cond, err_cond;
  logic          thr_prev_q, err_prev_q, ack_prev_q;
  irq_src_t      src;

  assign thr_eff = KW'(thr) + KW'(1);
  assign level   = (xfer_dir_e'(dir_in) == DIR_FROM_PERIPH) ? KW'(count)
                                                            : DEPTH_K - KW'(count);

  // Masking is part of the condition, so releasing the mask yields an edge
  assign thr_cond = fifo_en & ~svc_mask & ~dma_mode & (level >= thr_eff);
  assign err_cond = ~err_en_n & ~fault_n;

  assign src.thr = thr_cond & ~thr_prev_q;
  assign src.dma = ~svc_mask & dma_mode & dma_tc;
  assign src.err = err_cond & ~err_prev_q;
  assign src.ack = ack_en & ack_n & ~ack_prev_q;
  assign evt     = |src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_prev_q <= 1'b0;
      err_prev_q <= 1'b0;
      ack_prev_q <= 1'b1;
    end else begin
      thr_prev_q <= thr_cond;
      err_prev_q <= err_cond;
      ack_prev_q <= ack_n;
    end
  end

endmodule

// File: rtl/pp_irq_pulse.sv
module pp_irq_pulse #(
  parameter int PULSE_W = 2,
  localparam int PW     = $clog2(PULSE_W + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic drive_en,
  output logic drive_val
);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = evt | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (evt)                cnt_d = PW'(PULSE_W);
    else if (cnt_q != '0)   cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign drive_en  = (cnt_q != '0);
  assign drive_val = ~drive_en;

endmodule

// File: rtl/pp_fifo_irq.sv
module pp_fifo_irq #(
  parameter int DEPTH   = 16,
  parameter int DW      = 8,
  parameter int TW      = 4,
  parameter int PULSE_W = 2,
  localparam int CW     = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          svc_mask,
  input  logic          dma_mode,
  input  logic          dir_in,
  input  logic          err_en_n,
  input  logic          ack_en,
  input  logic [TW-1:0] thr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] fifo_count,
  output logic          fifo_full,
  output logic          fifo_empty,
  input  logic          dma_tc,
  input  logic          fault_n,
  input  logic          ack_n,
  output logic          irq_oe,
  output logic          irq_val
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       irq_evt;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  pp_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (fifo_en),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .pop_data  (pop_data),
    .count     (fifo_count),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  pp_irq_detect #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_detect (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fifo_en  (fifo_en),
    .svc_mask (svc_mask),
    .dma_mode (dma_mode),
    .dir_in   (dir_in),
    .err_en_n (err_en_n),
    .ack_en   (ack_en),
    .thr      (thr),
    .count    (fifo_count),
    .dma_tc   (dma_tc),
    .fault_n  (fault_n),
    .ack_n    (ack_n),
    .evt      (irq_evt)
  );

  pp_irq_pulse #(.PULSE_W(PULSE_W)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .evt       (irq_evt),
    .drive_en  (irq_oe),
    .drive_val (irq_val)
  );

endmodule

// File: rtl/pp_fifo_irq_chk.sv
module pp_fifo_irq_chk #(
  parameter int DEPTH   = 16,
  parameter int PULSE_W = 2,
  parameter int CW      = 5,
  localparam int RW     = $clog2(PULSE_W + 1) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          push,
  input logic          pop,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic [CW-1:0] fifo_count,
  input logic          svc_mask,
  input logic          dma_mode,
  input logic          dma_tc,
  input logic          err_en_n,
  input logic          fault_n,
  input logic          ack_en,
  input logic          ack_n,
  input logic          irq_evt,
  input logic          irq_oe
);

  logic          armed_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // Length of the current drive run since the last event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  run_q <= '0;
    else if (irq_evt)                            run_q <= '0;
    else if (irq_oe && run_q != {RW{1'b1}})      run_q <= run_q + RW'(1);
    else if (!irq_oe)                            run_q <= '0;
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  // R1
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && fifo_full && push && !pop) |=> fifo_count == CW'(DEPTH));

  // R1
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && fifo_empty && pop && !push) |=> fifo_count == '0);

  // R2
  fifo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> fifo_count == '0);

  // R7
  dma_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && !svc_mask && dma_tc) |=> irq_oe);

  // R8
  fault_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !err_en_n && $fell(fault_n)) |=> irq_oe);

  // R9
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && ack_en && $rose(ack_n)) |=> irq_oe);

  // R10
  evt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |=> irq_oe);

  // R10
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> run_q < RW'(PULSE_W));

endmodule

bind pp_fifo_irq pp_fifo_irq_chk #(.DEPTH(DEPTH), .PULSE_W(PULSE_W), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .fifo_en    (fifo_en),
  .push       (push),
  .pop        (pop),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .fifo_count (fifo_count),
  .svc_mask   (svc_mask),
  .dma_mode   (dma_mode),
  .dma_tc     (dma_tc),
  .err_en_n   (err_en_n),
  .fault_n    (fault_n),
  .ack_en     (ack_en),
  .ack_n      (ack_n),
  .irq_evt    (irq_evt),
  .irq_oe     (irq_oe)
);

// File: tb/pp_fifo_irq_bench.sv
module pp_fifo_irq_bench;

  localparam int DEPTH   = 16;
  localparam int DW      = 8;
  localparam int TW      = 4;
  localparam int PULSE_W = 3;
  localparam int CW      = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fifo_en = 1'b0, svc_mask = 1'b1, dma_mode = 1'b0, dir_in = 1'b0;
  logic          err_en_n = 1'b1, ack_en = 1'b0;
  logic [TW-1:0] thr = '0;
  logic          push = 1'b0, pop = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic [DW-1:0] pop_data;
  logic [CW-1:0] fifo_count;
  logic          fifo_full, fifo_empty;
  logic          dma_tc = 1'b0, fault_n = 1'b1, ack_n = 1'b1;
  logic          irq_oe, irq_val;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int width  = 0;
  int exp_w  = PULSE_W;
  bit oe_q   = 1'b0;

  always #2 clk = ~clk;

  pp_fifo_irq #(.DEPTH(DEPTH), .DW(DW), .TW(TW), .PULSE_W(PULSE_W)) u_pp_fifo_irq (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .svc_mask(svc_mask),
    .dma_mode(dma_mode), .dir_in(dir_in), .err_en_n(err_en_n), .ack_en(ack_en),
    .thr(thr), .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
    .fifo_count(fifo_count), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .dma_tc(dma_tc), .fault_n(fault_n), .ack_n(ack_n),
    .irq_oe(irq_oe), .irq_val(irq_val)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pulse monitor: counts line drives and checks their length (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_oe && !oe_q) begin
        pulses++;
        width = 1;
      end else if (irq_oe) begin
        width++;
      end else if (oe_q) begin
        check(width == exp_w, "R10", "pulse width", width, exp_w);
      end
      if (irq_oe) check(irq_val == 1'b0, "R10", "value while driving", int'(irq_val), 0);
      oe_q = irq_oe;
    end
  end

  task automatic settle();
    repeat (PULSE_W + 5) @(negedge clk);
    #1;
  endtask

  task automatic expect_pulses(input string req, input string what, input int exp);
    check(pulses == exp, req, what, pulses, exp);
    pulses = 0;
  endtask

  task automatic do_push(input logic [DW-1:0] v);
    @(negedge clk);
    push = 1'b1;
    push_data = v;
    @(negedge clk);
    push = 1'b0;
    #1;
  endtask

  task automatic do_pop(output logic [DW-1:0] v);
    @(negedge clk);
    v = pop_data;
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    #1;
  endtask

  task automatic next_sample();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL R10 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R11 / R2: reset state
    check(irq_oe == 1'b0, "R11", "oe after reset", int'(irq_oe), 0);
    check(irq_val == 1'b1, "R11", "val after reset", int'(irq_val), 1);
    check(fifo_count == 0, "R2", "count after reset", int'(fifo_count), 0);
    check(fifo_empty == 1'b1, "R2", "empty after reset", int'(fifo_empty), 1);

    // Sweep of both directions and every threshold (R1, R3, R4, R5)
    for (int d = 0; d < 2; d++) begin
      for (int t = 0; t < 16; t++) begin
        fifo_en = 1'b0; svc_mask = 1'b1; dir_in = d[0]; thr = t[TW-1:0];
        settle();
        fifo_en = 1'b1;
        settle();
        pulses = 0;
        svc_mask = 1'b0;
        settle();
        // R5: release of mask with condition already true fires at once
        expect_pulses("R5", "mask release", (d == 0) ? 1 : 0);
        for (int i = 0; i < DEPTH; i++) begin
          do_push(8'(i * 7 + t + d * 64));
          check(fifo_count == CW'(i + 1), "R1", "count after push", int'(fifo_count), i + 1);
          next_sample();
          if (d == 1)
            check(pulses == ((i + 1 >= t + 1) ? 1 : 0), "R3", "read threshold",
                  pulses, (i + 1 >= t + 1) ? 1 : 0);
        end
        check(fifo_full == 1'b1, "R1", "full flag", int'(fifo_full), 1);
        do_push(8'hEE);
        check(fifo_count == CW'(DEPTH), "R1", "push when full", int'(fifo_count), DEPTH);
        settle();
        // R5: one pulse for a sustained condition
        expect_pulses(d == 1 ? "R5" : "R4", "push phase", d == 1 ? 1 : 0);
        for (int j = 0; j < DEPTH; j++) begin
          do_pop(got);
          check(got == 8'(j * 7 + t + d * 64), "R1", "pop order", int'(got), (j * 7 + t + d * 64) % 256);
          next_sample();
          if (d == 0)
            check(pulses == ((j + 1 >= t + 1) ? 1 : 0), "R4", "write threshold",
                  pulses, (j + 1 >= t + 1) ? 1 : 0);
        end
        settle();
        expect_pulses("R4", "pop phase", d == 0 ? 1 : 0);
      end
    end

    // R1: pop on empty ignored
    fifo_en = 1'b0; svc_mask = 1'b1; settle(); fifo_en = 1'b1; settle();
    pulses = 0;
    do_pop(got);
    check(fifo_count == 0, "R1", "pop when empty", int'(fifo_count), 0);
    check(fifo_empty == 1'b1, "R1", "empty after empty pop", int'(fifo_empty), 1);

    // R2: disabling discards contents
    for (int i = 0; i < 5; i++) do_push(8'(i));
    check(fifo_count == 5, "R2", "count before disable", int'(fifo_count), 5);
    fifo_en = 1'b0;
    next_sample();
    check(fifo_count == 0, "R2", "count while disabled", int'(fifo_count), 0);
    fifo_en = 1'b1;
    do_push(8'h3C);
    do_pop(got);
    check(got == 8'h3C, "R2", "fresh data after disable", int'(got), 'h3C);

    // R6: mask blocks threshold and DMA events
    dir_in = 1'b1; thr = '0; dma_mode = 1'b0;
    do_push(8'h11);
    settle();
    expect_pulses("R6", "masked threshold", 0);
    dma_mode = 1'b1;
    @(negedge clk); dma_tc = 1'b1; @(negedge clk); dma_tc = 1'b0;
    settle();
    expect_pulses("R6", "masked dma tc", 0);

    // R7: DMA mode, threshold ignored; TC fires
    svc_mask = 1'b0;
    settle();
    expect_pulses("R7", "threshold in dma mode", 0);
    @(negedge clk); dma_tc = 1'b1;
    @(posedge clk); #1;
    check(irq_oe == 1'b1, "R10", "oe after tc edge", int'(irq_oe), 1);
    check(irq_val == 1'b0, "R10", "val after tc edge", int'(irq_val), 0);
    @(negedge clk); dma_tc = 1'b0;
    settle();
    expect_pulses("R7", "dma tc", 1);

    // R10: retrigger during a pulse stretches it by the gap
    exp_w = PULSE_W + 2;
    @(negedge clk); dma_tc = 1'b1;
    @(negedge clk); dma_tc = 1'b0;
    @(negedge clk); dma_tc = 1'b1;
    @(negedge clk); dma_tc = 1'b0;
    settle();
    expect_pulses("R10", "retrigger", 1);
    exp_w = PULSE_W;
    svc_mask = 1'b1; dma_mode = 1'b0; fifo_en = 1'b0;
    settle();
    pulses = 0;

    // R8: fault line
    err_en_n = 1'b0;
    @(negedge clk); fault_n = 1'b0; settle();
    expect_pulses("R8", "fault fall", 1);
    @(negedge clk); fault_n = 1'b1; settle();
    expect_pulses("R8", "fault rise", 0);
    err_en_n = 1'b1;
    @(negedge clk); fault_n = 1'b0; settle();
    expect_pulses("R8", "fault fall disabled", 0);
    @(negedge clk); err_en_n = 1'b0; settle();
    expect_pulses("R8", "enable with fault low", 1);
    err_en_n = 1'b1; fault_n = 1'b1; settle();
    pulses = 0;

    // R9: acknowledge line
    ack_en = 1'b1;
    @(negedge clk); ack_n = 1'b0; settle();
    expect_pulses("R9", "ack fall", 0);
    @(negedge clk); ack_n = 1'b1; settle();
    expect_pulses("R9", "ack rise", 1);
    ack_en = 1'b0;
    @(negedge clk); ack_n = 1'b0; settle();
    @(negedge clk); ack_n = 1'b1; settle();
    expect_pulses("R9", "ack disabled", 0);
    check(irq_oe == 1'b0, "R11", "line released at end", int'(irq_oe), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule